// File: doc/BRIEF.md
# RS-485 Nine-Bit Transmitter with Automatic Driver Enable

This block serialises bytes taken from an external first-word-fall-through FIFO onto an asynchronous line. It uses a ninth bit to mark each character as an address or as data. The ninth bit is fixed by the stick-parity settings, so a multidrop master can flag address characters. When stick parity is off, the ninth bit is ordinary even or odd parity. When parity is off, the ninth bit is left out. Bit timing comes from an external baud tick: one tick ends each bit period.

The block also drives the enable pin of an RS-485 line driver. With automatic direction control on, the enable goes active one full bit period before the first start bit. It stays active across back-to-back characters. It drops a programmable number of bit periods after the stop bit of the last character has left the line. If new data arrives during that tail, the countdown is abandoned and transmission resumes with the driver still on. A polarity bit selects whether logic 1 or logic 0 is the active level.

Top module: `rs485_tx`

## Requirements
- R1: The line idles at 1. A frame is one start bit (0), then eight data bits with the least significant bit first, then the optional ninth bit, then one stop bit (1). Each bit lasts from one sampled baud tick to the next. Ticks are at least two clock cycles apart.
- R2: With parity, stick and even select all set, the ninth bit is 0.
- R3: With parity and stick set and even select clear, the ninth bit is 1.
- R4: With parity set and stick clear, the ninth bit makes the count of ones across the data and the ninth bit even (even select set) or odd (even select clear).
- R5: With parity clear, no ninth bit is sent, and the stop bit follows data bit 7 directly.
- R6: `fifo_pop` is a single-cycle pulse, issued once per character in the first cycle of that character's start bit.
- R7: From idle, the first tick that sees the FIFO non-empty makes the enable active. The start bit begins on the following tick, so the enable leads the start bit by one full bit period.
- R8: With automatic direction on, the enable turns inactive `turn_delay` ticks after the tick that ends the last stop bit. A delay of 0 turns it inactive on that tick itself.
- R9: If the FIFO is non-empty at a tick while the turn-off delay is running, the next start bit begins on that tick and the enable stays active.
- R10: A character waiting in the FIFO when a stop bit ends starts on the very next bit period, with no idle bit in between.
- R11: With `de_invert` set, the active enable level is 0 and the inactive level is 1.
- R12: With automatic direction off, `de_out` stays at the inactive level (the value of `de_invert`) at all times.
- R13: During reset and right after it, `txd` is 1, `fifo_pop` is 0 and `de_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_nempty | input | 1 | FIFO holds at least one byte |
| fifo_data | input | DATA_W | Byte at the head of the FIFO |
| baud_tick | input | 1 | One-cycle pulse marking the end of each bit period |
| par_en | input | 1 | Ninth bit present |
| par_even | input | 1 | Even select |
| par_stick | input | 1 | Stick select |
| auto_dir_en | input | 1 | Automatic driver-enable control |
| de_invert | input | 1 | Makes the active enable level 0 |
| turn_delay | input | DLY_W | Turn-off delay in bit periods |
| txd | output | 1 | Serial line |
| fifo_pop | output | 1 | Removes the head byte from the FIFO |
| de_out | output | 1 | Driver enable |

## Verification
Every output is a register that changes on the clock edge where a baud tick is sampled. The bench counts ticks from the first tick that sees data: the enable is due after tick 0, the start bit and pop after tick 1, bit i of character j after tick 2+i+L·j (L is 11 or 10), and the enable drop after tick end+`turn_delay`. After each tick edge it waits for the falling clock edge, then compares `txd`, `fifo_pop` and `de_out` with values it derives from the tick number. For the cancelled-countdown case, the late byte is written right after the sample of a chosen tick. That character's start is then expected on the next tick.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP,
    ST_HOLD
  } tx_state_e;
endpackage

// File: rtl/rs485_ninth_bit.sv
module rs485_ninth_bit #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] char_data,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              ninth_used,
  output logic              ninth_val
);
  always_comb begin
    ninth_used = par_en;
    if (par_stick) begin
      ninth_val = ~par_even;
    end else if (par_even) begin
      ninth_val = ^char_data;
    end else begin
      ninth_val = ~(^char_data);
    end
  end
endmodule

// File: rtl/rs485_tx_seq.sv
module rs485_tx_seq
  import rs485_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              fifo_nempty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              auto_dir_en,
  input  logic [DLY_W-1:0]  turn_delay,
  input  logic              ninth_used,
  input  logic              ninth_val,
  output logic [DATA_W-1:0] char_data,
  output logic              txd,
  output logic              fifo_pop,
  output logic              busy_nxt
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(DATA_W - 1);
  localparam logic [DLY_W-1:0] ONE_CNT  = DLY_W'(1);

  tx_state_e         state_q, state_d;
  logic [BIT_W-1:0]  idx_q, idx_d;
  logic [DLY_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] data_q;
  logic              txd_q, txd_d;
  logic              pop_q;
  logic              load;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    txd_d   = txd_q;
    load    = 1'b0;
    if (baud_tick) begin
      case (state_q)
        ST_IDLE: begin
          if (fifo_nempty) state_d = ST_LEAD;
        end
        ST_LEAD: begin
          load    = 1'b1;
          state_d = ST_START;
          txd_d   = 1'b0;
        end
        ST_START: begin
          state_d = ST_DATA;
          idx_d   = '0;
          txd_d   = data_q[0];
        end
        ST_DATA: begin
          if (idx_q == LAST_IDX) begin
            if (ninth_used) begin
              state_d = ST_NINTH;
              txd_d   = ninth_val;
            end else begin
              state_d = ST_STOP;
              txd_d   = 1'b1;
            end
          end else begin
            idx_d = idx_q + 1'b1;
            txd_d = data_q[idx_q + 1'b1];
          end
        end
        ST_NINTH: begin
          state_d = ST_STOP;
          txd_d   = 1'b1;
        end
        ST_STOP: begin
          if (fifo_nempty) begin
            load    = 1'b1;
            state_d = ST_START;
            txd_d   = 1'b0;
          end else if (auto_dir_en && (turn_delay != '0)) begin
            state_d = ST_HOLD;
            cnt_d   = turn_delay;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (fifo_nempty) begin
            load    = 1'b1;
            state_d = ST_START;
            txd_d   = 1'b0;
          end else if (cnt_q == ONE_CNT) begin
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      txd_q   <= 1'b1;
      pop_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      txd_q   <= txd_d;
      pop_q   <= load;
      if (load) data_q <= fifo_data;
    end
  end

  assign busy_nxt  = (state_d != ST_IDLE);
  assign char_data = data_q;
  assign txd       = txd_q;
  assign fifo_pop  = pop_q;

  // R6
  pop_single_chk: assert property (@(posedge clk) disable iff (rst)
    pop_q |=> !pop_q);

  // R6
  pop_start_chk: assert property (@(posedge clk) disable iff (rst)
    pop_q |-> !txd_q);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> txd_q);

  // R8
  hold_count_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD) |-> (cnt_q != '0));
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic auto_dir_en,
  input  logic de_invert,
  input  logic busy_nxt,
  output logic de_out
);
  logic de_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q <= 1'b0;
    end else if (auto_dir_en) begin
      de_q <= busy_nxt ^ de_invert;
    end else begin
      de_q <= de_invert;
    end
  end

  assign de_out = de_q;
endmodule

// File: rtl/rs485_tx.sv
module rs485_tx #(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_nempty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              baud_tick,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              auto_dir_en,
  input  logic              de_invert,
  input  logic [DLY_W-1:0]  turn_delay,
  output logic              txd,
  output logic              fifo_pop,
  output logic              de_out
);
  logic [DATA_W-1:0] char_data;
  logic              ninth_used;
  logic              ninth_val;
  logic              busy_nxt;

  rs485_ninth_bit #(.DATA_W(DATA_W)) ninth_i (
    .char_data (char_data),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .ninth_used(ninth_used),
    .ninth_val (ninth_val)
  );

  rs485_tx_seq #(.DATA_W(DATA_W), .DLY_W(DLY_W)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .fifo_nempty(fifo_nempty),
    .fifo_data  (fifo_data),
    .auto_dir_en(auto_dir_en),
    .turn_delay (turn_delay),
    .ninth_used (ninth_used),
    .ninth_val  (ninth_val),
    .char_data  (char_data),
    .txd        (txd),
    .fifo_pop   (fifo_pop),
    .busy_nxt   (busy_nxt)
  );

  rs485_dir_ctrl dir_i (
    .clk        (clk),
    .rst        (rst),
    .auto_dir_en(auto_dir_en),
    .de_invert  (de_invert),
    .busy_nxt   (busy_nxt),
    .de_out     (de_out)
  );

  // R7
  de_during_low_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_dir_en && !txd) |-> (de_out == !de_invert));

  // R7
  de_lead_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(txd) && auto_dir_en && $past(auto_dir_en)) |-> ($past(de_out) == !de_invert));
endmodule

// File: tb/rs485_tx_tb.sv
module rs485_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       par_en = 1'b1, par_even = 1'b1, par_stick = 1'b1;
  logic       auto_dir_en = 1'b1, de_invert = 1'b0;
  logic [7:0] turn_delay = 8'd0;
  logic       txd, fifo_pop, de_out;
  logic       fifo_nempty;
  logic [7:0] fifo_data;

  logic [7:0] q_mem [0:15];
  int q_rd = 0, q_wr = 0;
  int tick_div = 0;
  int checks = 0, errors = 0;
  logic [7:0] bytes [0:3];

  assign fifo_nempty = (q_rd != q_wr);
  assign fifo_data   = q_mem[q_rd % 16];

  rs485_tx dut_i (
    .clk(clk), .rst(rst), .fifo_nempty(fifo_nempty), .fifo_data(fifo_data),
    .baud_tick(baud_tick), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .auto_dir_en(auto_dir_en), .de_invert(de_invert),
    .turn_delay(turn_delay), .txd(txd), .fifo_pop(fifo_pop), .de_out(de_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_div  = (tick_div + 1) % TICK_DIV;
    baud_tick = (tick_div == 0);
    if (fifo_pop) q_rd = q_rd + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    q_mem[q_wr % 16] = b;
    q_wr = q_wr + 1;
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!baud_tick);
    @(negedge clk);
  endtask

  function automatic logic exp_ninth(input logic [7:0] b);
    if (par_stick) return ~par_even;
    if (par_even) return ^b;
    return ~(^b);
  endfunction

  // Sends n bytes from bytes[]; late_k >= 0 pushes the second byte after tick late_k.
  task automatic run_case(input string txd_req, input string de_req, input int n,
                          input int d, input int late_k);
    int fl, last_end, deff, total;
    int starts [0:3];
    fl = par_en ? 11 : 10;
    for (int j = 0; j < n; j++) starts[j] = 1 + fl * j;
    if (late_k >= 0) starts[1] = late_k + 1;
    last_end = starts[n-1] + fl;
    deff = auto_dir_en ? d : 0;
    total = last_end + deff + 2;
    turn_delay = 8'(d);
    @(negedge clk);
    check(de_req, "enable before data", int'(de_out), int'(de_invert));
    for (int j = 0; j < n; j++) if (late_k < 0 || j == 0) push(bytes[j]);
    for (int k = 0; k <= total; k++) begin
      logic et, ep, ed;
      wait_tick();
      et = 1'b1; ep = 1'b0;
      for (int j = 0; j < n; j++) begin
        if (k == starts[j]) ep = 1'b1;
        if (k >= starts[j] && k < starts[j] + fl) begin
          int off;
          off = k - starts[j];
          if (off == 0) et = 1'b0;
          else if (off <= 8) et = bytes[j][off-1];
          else if (off == 9 && par_en) et = exp_ninth(bytes[j]);
          else et = 1'b1;
        end
      end
      ed = auto_dir_en ? ((k < last_end + deff) ^ de_invert) : de_invert;
      check(txd_req, $sformatf("txd tick %0d", k), int'(txd), int'(et));
      check("R6", $sformatf("pop tick %0d", k), int'(fifo_pop), int'(ep));
      check(de_req, $sformatf("enable tick %0d", k), int'(de_out), int'(ed));
      if (k == late_k) push(bytes[1]);
    end
    check("R6", "fifo drained", q_wr - q_rd, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13", "txd in reset", int'(txd), 1);
    check("R13", "pop in reset", int'(fifo_pop), 0);
    check("R13", "enable in reset", int'(de_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R13", "txd after reset", int'(txd), 1);
    check("R13", "enable after reset", int'(de_out), 0);
  endtask

  task automatic t_stick_data();  // R2, R1, R7, R8 delay 0
    par_en = 1; par_even = 1; par_stick = 1; auto_dir_en = 1; de_invert = 0;
    bytes[0] = 8'hA5;
    run_case("R2", "R8", 1, 0, -1);
  endtask

  task automatic t_stick_addr();  // R3, R10, R8 delay 3
    par_en = 1; par_even = 0; par_stick = 1;
    bytes[0] = 8'h3C; bytes[1] = 8'hFF; bytes[2] = 8'h01;
    run_case("R3", "R10", 3, 3, -1);
  endtask

  task automatic t_parity();  // R4
    par_en = 1; par_even = 1; par_stick = 0;
    bytes[0] = 8'h07; bytes[1] = 8'h81;
    run_case("R4", "R7", 2, 1, -1);
    par_even = 0;
    bytes[0] = 8'h07; bytes[1] = 8'h00;
    run_case("R4", "R7", 2, 1, -1);
  endtask

  task automatic t_no_parity();  // R5
    par_en = 0;
    bytes[0] = 8'h5A; bytes[1] = 8'hC3;
    run_case("R5", "R10", 2, 2, -1);
    par_en = 1;
  endtask

  task automatic t_invert();  // R11
    par_stick = 1; par_even = 1; de_invert = 1;
    @(negedge clk);
    bytes[0] = 8'h96;
    run_case("R1", "R11", 1, 2, -1);
    de_invert = 0;
    @(negedge clk);
  endtask

  task automatic t_manual();  // R12
    auto_dir_en = 0; de_invert = 1;
    @(negedge clk);
    bytes[0] = 8'h11; bytes[1] = 8'hEE;
    run_case("R1", "R12", 2, 4, -1);
    de_invert = 0;
    @(negedge clk);
    check("R12", "enable level follows invert bit", int'(de_out), 0);
    auto_dir_en = 1;
  endtask

  task automatic t_cancel();  // R9: byte 0 ends at tick 12, second byte pushed after tick 13
    par_en = 1; par_even = 1; par_stick = 1;
    bytes[0] = 8'h42; bytes[1] = 8'hBD;
    run_case("R9", "R9", 2, 5, 13);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_stick_data();
    t_stick_addr();
    t_parity();
    t_no_parity();
    t_invert();
    t_manual();
    t_cancel();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule